// File: doc/BRIEF.md
# Dual-Bus Control and Status Register

This block is a single 32-bit control and status word that two independent bus masters can reach. One is a host-side bus and the other is a local-side bus. Each side has its own write strobe, its own write data and its own read data port. The word holds four 4-bit bus command codes and a general purpose output. It also holds three software-driven lines for bit-banging a serial EEPROM, a one-shot trigger for reloading the local configuration, a software hold on local-side reset, and an init-done flag. Three fields are read-only and reflect live pins: a general purpose input, the EEPROM data return line, and an EEPROM presence flag.

The register drives its pin outputs directly from the stored bits. It emits a one-cycle pulse when a configuration reload is requested. It drives a local reset output from the software hold bit. It raises a retry request for host accesses for as long as local init has not completed. An active-low bypass pin forces the init-done flag to read as set.

Software reset never clears the register. Only the global hardware reset returns every field to its reset value.

Top module: `busCtrlStatusReg`

## Requirements
- R1: After hardware reset the read word is 0x0001767E when all input pins are low and the bypass pin is high. That is: command nibbles [3:0]=0xE, [7:4]=0x7, [11:8]=0x6 and [15:12]=0x7, with bit 16 set. After reset gpOut is 1; eeClk, eeSel, eeDout, reloadPulse and localRstOut are 0; hostRetry is 1.
- R2: Bits 15:0 (four 4-bit command codes) are written by a write strobe from either bus. The new value is readable on the cycle after the write edge.
- R3: Bit 16 drives gpOut. Bits 24, 25 and 26 drive eeClk, eeSel and eeDout. All four are writable from either bus.
- R4: Bit 17 reads gpIn and bit 27 reads eeDin. Each passes through a two-flop synchronizer, so a change at the pin shows after the second rising clock edge and not after the first. Bit 28 reads eePresent directly. Writes to bits 17, 27 and 28 have no effect.
- R5: Bits 23:18 always read 0, whatever is written to them.
- R6: A write with bit 29 set, while bit 29 holds 0, sets bit 29 and gives reloadPulse high for exactly one cycle. A write of 1 while bit 29 is already 1 gives no pulse. A cycle with reloadDone high clears bit 29, after which a new write re-arms it.
- R7: Bit 30 drives localRstOut. Only a host-side write changes bit 30; local-side writes leave it unchanged. Setting bit 30 does not alter any other field.
- R8: Bit 31 is the init-done flag and is writable from either bus. It reads as 1 while initBypassN is low. hostRetry is high exactly when bit 31 reads 0.
- R9: When both buses write in the same cycle, the host-side data is stored in every field.
- R10: hostRdData and localRdData always carry the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Global hardware reset, active low |
| hostWrEn | input | 1 | Host-side write strobe |
| hostWrData | input | 32 | Host-side write data |
| hostRdData | output | 32 | Host-side read data |
| localWrEn | input | 1 | Local-side write strobe |
| localWrData | input | 32 | Local-side write data |
| localRdData | output | 32 | Local-side read data |
| gpIn | input | 1 | General purpose input pin (asynchronous) |
| gpOut | output | 1 | General purpose output pin |
| eeClk | output | 1 | Serial EEPROM clock line |
| eeSel | output | 1 | Serial EEPROM chip select line |
| eeDout | output | 1 | Serial EEPROM data toward the device |
| eeDin | input | 1 | Serial EEPROM data from the device (asynchronous) |
| eePresent | input | 1 | EEPROM presence indication |
| reloadDone | input | 1 | Pulse marking the end of a configuration reload |
| reloadPulse | output | 1 | One-cycle reload request |
| localRstOut | output | 1 | Local-side reset, active high |
| initBypassN | input | 1 | Active-low pin forcing init-done to read as set |
| hostRetry | output | 1 | Retry request for host accesses |

## Verification
The assertions take reloadDone to be a pulse that arrives only while a reload is outstanding. They also take eePresent and initBypassN to be stable, synchronous levels, since these two pins are read without a synchronizer. The stimulus changes every input at the falling clock edge, raises reloadDone for a single cycle only after bit 29 has been seen set, and moves the bypass pin only inside directed tests. The same-cycle collision case is driven from table rows that raise both strobes together.

// File: rtl/csrPkg.sv
package csrPkg;
  localparam int CSR_W      = 32;
  localparam int CMD_NIB    = 4;
  localparam int CMD_W      = 4 * CMD_NIB;
  localparam int BIT_GPO    = 16;
  localparam int BIT_GPI    = 17;
  localparam int RSV_LO     = 18;
  localparam int RSV_HI     = 23;
  localparam int BIT_EECLK  = 24;
  localparam int BIT_EESEL  = 25;
  localparam int BIT_EEDO   = 26;
  localparam int BIT_EEDI   = 27;
  localparam int BIT_EEPRES = 28;
  localparam int BIT_RELOAD = 29;
  localparam int BIT_SWRST  = 30;
  localparam int BIT_INIT   = 31;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic hostWr;
    logic localWr;
    logic fieldWr;
    logic swRstWr;
    logic reloadFire;
    logic reloadClear;
  } csrStrobe_t;

  // Writable fields taken from the winning write source
  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic             gpo;
    logic             eeClk;
    logic             eeSel;
    logic             eeDo;
    logic             swRst;
    logic             init;
  } csrFields_t;
endpackage

// File: rtl/csrSync.sv
module csrSync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ[0] <= '0;
    else       stageQ[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= '0;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/csrCtrl.sv
module csrCtrl
  import csrPkg::*;
(
  input  logic             hostWrEn,
  input  logic [CSR_W-1:0] hostWrData,
  input  logic             localWrEn,
  input  logic [CSR_W-1:0] localWrData,
  input  logic             reloadBusy,
  input  logic             reloadDone,
  output csrStrobe_t       strobe,
  output csrFields_t       fields
);
  logic [CSR_W-1:0] srcData;
  logic             unusedSrcBits;

  // Host side wins for every field when both sides write
  assign srcData = hostWrEn ? hostWrData : localWrData;

  always_comb begin
    strobe             = '0;
    strobe.hostWr      = hostWrEn;
    strobe.localWr     = localWrEn;
    strobe.fieldWr     = hostWrEn | localWrEn;
    strobe.swRstWr     = hostWrEn;
    strobe.reloadFire  = (hostWrEn | localWrEn) & srcData[BIT_RELOAD] & ~reloadBusy;
    strobe.reloadClear = reloadDone & reloadBusy;
  end

  always_comb begin
    fields       = '0;
    fields.cmd   = srcData[CMD_W-1:0];
    fields.gpo   = srcData[BIT_GPO];
    fields.eeClk = srcData[BIT_EECLK];
    fields.eeSel = srcData[BIT_EESEL];
    fields.eeDo  = srcData[BIT_EEDO];
    fields.swRst = srcData[BIT_SWRST];
    fields.init  = srcData[BIT_INIT];
  end

  assign unusedSrcBits = ^{srcData[BIT_GPI], srcData[RSV_HI:RSV_LO],
                           srcData[BIT_EEDI], srcData[BIT_EEPRES]};
endmodule

// File: rtl/csrDatapath.sv
module csrDatapath
  import csrPkg::*;
#(
  parameter logic [CMD_W-1:0] CMD_RST     = 16'h767E,
  parameter logic             GPO_RST     = 1'b1,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  csrStrobe_t       strobe,
  input  csrFields_t       fields,
  input  logic             gpIn,
  input  logic             eeDin,
  input  logic             eePresent,
  input  logic             initBypassN,
  input  logic             reloadDone,
  output logic [CSR_W-1:0] rdWord,
  output logic             gpOut,
  output logic             eeClk,
  output logic             eeSel,
  output logic             eeDout,
  output logic             reloadBusy,
  output logic             reloadPulse,
  output logic             localRstOut,
  output logic             hostRetry
);
  logic [CMD_W-1:0] cmdQ;
  logic             gpoQ, eeClkQ, eeSelQ, eeDoQ;
  logic             reloadQ, pulseQ, swRstQ, initQ;
  logic [1:0]       pinSync;
  logic             initView;

  for (genvar n = 0; n < CMD_NIB; n++) begin : gCmd
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               cmdQ[n*4 +: 4] <= CMD_RST[n*4 +: 4];
      else if (strobe.fieldWr) cmdQ[n*4 +: 4] <= fields.cmd[n*4 +: 4];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gpoQ   <= GPO_RST;
      eeClkQ <= 1'b0;
      eeSelQ <= 1'b0;
      eeDoQ  <= 1'b0;
      initQ  <= 1'b0;
    end else if (strobe.fieldWr) begin
      gpoQ   <= fields.gpo;
      eeClkQ <= fields.eeClk;
      eeSelQ <= fields.eeSel;
      eeDoQ  <= fields.eeDo;
      initQ  <= fields.init;
    end
  end

  // Software reset hold: host side only, never clears this register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               swRstQ <= 1'b0;
    else if (strobe.swRstWr) swRstQ <= fields.swRst;
  end

  // Reload trigger: set on a 0-to-1 write, cleared by reloadDone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= 1'b0;
      pulseQ  <= 1'b0;
    end else begin
      pulseQ <= strobe.reloadFire;
      if (strobe.reloadClear)     reloadQ <= 1'b0;
      else if (strobe.reloadFire) reloadQ <= 1'b1;
    end
  end

  csrSync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uPinSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({eeDin, gpIn}),
    .syncOut (pinSync)
  );

  assign initView = initQ | ~initBypassN;

  always_comb begin
    rdWord               = '0;
    rdWord[CMD_W-1:0]    = cmdQ;
    rdWord[BIT_GPO]      = gpoQ;
    rdWord[BIT_GPI]      = pinSync[0];
    rdWord[BIT_EECLK]    = eeClkQ;
    rdWord[BIT_EESEL]    = eeSelQ;
    rdWord[BIT_EEDO]     = eeDoQ;
    rdWord[BIT_EEDI]     = pinSync[1];
    rdWord[BIT_EEPRES]   = eePresent;
    rdWord[BIT_RELOAD]   = reloadQ;
    rdWord[BIT_SWRST]    = swRstQ;
    rdWord[BIT_INIT]     = initView;
  end

  assign gpOut       = gpoQ;
  assign eeClk       = eeClkQ;
  assign eeSel       = eeSelQ;
  assign eeDout      = eeDoQ;
  assign reloadBusy  = reloadQ;
  assign reloadPulse = pulseQ;
  assign localRstOut = swRstQ;
  assign hostRetry   = ~initView;

  // R6
  reload_pulse_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    reloadPulse |-> rdWord[BIT_RELOAD]);

  // R6
  reload_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    reloadPulse |=> !reloadPulse);

  // R7
  local_swrst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.localWr && !strobe.hostWr) |=> $stable(localRstOut));

  // R8
  bypass_no_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    !initBypassN |-> !hostRetry);

  // R6
  reload_done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reloadDone && reloadBusy) |=> !rdWord[BIT_RELOAD]);
endmodule

// File: rtl/busCtrlStatusReg.sv
module busCtrlStatusReg
  import csrPkg::*;
#(
  parameter logic [CMD_W-1:0] CMD_RST     = 16'h767E,
  parameter logic             GPO_RST     = 1'b1,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic [CSR_W-1:0] hostWrData,
  output logic [CSR_W-1:0] hostRdData,
  input  logic             localWrEn,
  input  logic [CSR_W-1:0] localWrData,
  output logic [CSR_W-1:0] localRdData,
  input  logic             gpIn,
  output logic             gpOut,
  output logic             eeClk,
  output logic             eeSel,
  output logic             eeDout,
  input  logic             eeDin,
  input  logic             eePresent,
  input  logic             reloadDone,
  output logic             reloadPulse,
  output logic             localRstOut,
  input  logic             initBypassN,
  output logic             hostRetry
);
  csrStrobe_t       strobe;
  csrFields_t       fields;
  logic             reloadBusy;
  logic [CSR_W-1:0] rdWord;

  csrCtrl uCtrl (
    .hostWrEn    (hostWrEn),
    .hostWrData  (hostWrData),
    .localWrEn   (localWrEn),
    .localWrData (localWrData),
    .reloadBusy  (reloadBusy),
    .reloadDone  (reloadDone),
    .strobe      (strobe),
    .fields      (fields)
  );

  csrDatapath #(
    .CMD_RST     (CMD_RST),
    .GPO_RST     (GPO_RST),
    .SYNC_STAGES (SYNC_STAGES)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .fields      (fields),
    .gpIn        (gpIn),
    .eeDin       (eeDin),
    .eePresent   (eePresent),
    .initBypassN (initBypassN),
    .reloadDone  (reloadDone),
    .rdWord      (rdWord),
    .gpOut       (gpOut),
    .eeClk       (eeClk),
    .eeSel       (eeSel),
    .eeDout      (eeDout),
    .reloadBusy  (reloadBusy),
    .reloadPulse (reloadPulse),
    .localRstOut (localRstOut),
    .hostRetry   (hostRetry)
  );

  assign hostRdData  = rdWord;
  assign localRdData = rdWord;

  // R9
  host_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && localWrEn) |=> hostRdData[CMD_W-1:0] == $past(hostWrData[CMD_W-1:0]));

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRdData[RSV_HI:RSV_LO] == '0);

  // R3
  gpo_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    gpOut == localRdData[BIT_GPO]);
endmodule

// File: tb/tb_busCtrlStatusReg.sv
module tb_busCtrlStatusReg;
  logic        clk = 1'b0;
  logic        rstN;
  logic        hostWrEn, localWrEn;
  logic [31:0] hostWrData, localWrData;
  logic [31:0] hostRdData, localRdData;
  logic        gpIn, gpOut, eeClk, eeSel, eeDout, eeDin, eePresent;
  logic        reloadDone, reloadPulse, localRstOut, initBypassN, hostRetry;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  busCtrlStatusReg dut (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .localWrEn(localWrEn), .localWrData(localWrData), .localRdData(localRdData),
    .gpIn(gpIn), .gpOut(gpOut), .eeClk(eeClk), .eeSel(eeSel), .eeDout(eeDout),
    .eeDin(eeDin), .eePresent(eePresent), .reloadDone(reloadDone),
    .reloadPulse(reloadPulse), .localRstOut(localRstOut),
    .initBypassN(initBypassN), .hostRetry(hostRetry)
  );

  // Vector: {hostWr, hostData, localWr, localData, expectedRead}
  localparam int NVEC = 5;
  localparam logic [97:0] VEC [NVEC] = '{
    {1'b1, 32'h12345678, 1'b0, 32'h00000000, 32'h02005678},
    {1'b0, 32'h00000000, 1'b1, 32'h0F0FAAAA, 32'h0701AAAA},
    {1'b1, 32'h00000001, 1'b1, 32'h07FFFFFF, 32'h00000001},
    {1'b0, 32'hFFFFFFFF, 1'b0, 32'hFFFFFFFF, 32'h00000001},
    {1'b0, 32'h00000000, 1'b1, 32'h0000C3A5, 32'h0000C3A5}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
    testsRun++;
    if (hostRdData !== localRdData) begin
      testsFailed++;
      $display("FAIL R10: actual %h expected %h", localRdData, hostRdData);
    end
  endtask

  task automatic busWrite(logic hw, logic [31:0] hd, logic lw, logic [31:0] ld);
    @(negedge clk);
    hostWrEn = hw; hostWrData = hd; localWrEn = lw; localWrData = ld;
    @(negedge clk);
    hostWrEn = 1'b0; localWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [31:0] cur;
    rstN = 1'b0; hostWrEn = 1'b0; localWrEn = 1'b0;
    hostWrData = '0; localWrData = '0;
    gpIn = 1'b0; eeDin = 1'b0; eePresent = 1'b0;
    reloadDone = 1'b0; initBypassN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 word", hostRdData, 32'h0001767E);
    check("R1 pins", {27'd0, gpOut, eeClk, eeSel, eeDout, reloadPulse},
          {27'd0, 5'b10000});
    check("R1 rst/retry", {30'd0, localRstOut, hostRetry}, 32'd1);

    // R2 R9 table walk
    for (int i = 0; i < NVEC; i++) begin
      busWrite(VEC[i][97], VEC[i][96:65], VEC[i][64], VEC[i][63:32]);
      check($sformatf("R2/R9 vec%0d", i), hostRdData, VEC[i][31:0]);
    end

    // R3 pin outputs
    busWrite(1'b1, 32'h07010000, 1'b0, '0);
    check("R3 pins high", {28'd0, gpOut, eeClk, eeSel, eeDout}, 32'hF);
    busWrite(1'b0, '0, 1'b1, 32'h00000000);
    check("R3 pins low", {28'd0, gpOut, eeClk, eeSel, eeDout}, 32'h0);

    // R4 synchronized inputs and presence
    @(negedge clk);
    gpIn = 1'b1; eeDin = 1'b1; eePresent = 1'b1;
    #1 check("R4 present", {31'd0, hostRdData[28]}, 32'd1);
    @(negedge clk);
    check("R4 one edge", {30'd0, hostRdData[27], hostRdData[17]}, 32'd0);
    @(negedge clk);
    check("R4 two edges", {30'd0, hostRdData[27], hostRdData[17]}, 32'd3);
    busWrite(1'b1, 32'h00001234, 1'b0, '0);
    check("R4 write ignored hi", hostRdData, 32'h18021234);
    gpIn = 1'b0; eeDin = 1'b0; eePresent = 1'b0;
    repeat (2) @(negedge clk);
    busWrite(1'b1, 32'h18021234, 1'b0, '0);
    check("R4 write ignored lo", hostRdData, 32'h00001234);

    // R5 reserved bits
    busWrite(1'b0, '0, 1'b1, 32'h00FC0001);
    check("R5 reserved", hostRdData, 32'h00000001);

    // R7 software reset hold
    cur = hostRdData;
    busWrite(1'b1, cur | 32'h40000000, 1'b0, '0);
    check("R7 set", {31'd0, localRstOut}, 32'd1);
    check("R7 no clear", hostRdData, cur | 32'h40000000);
    busWrite(1'b0, '0, 1'b1, cur);
    check("R7 local ignored", {31'd0, localRstOut}, 32'd1);
    busWrite(1'b1, cur, 1'b0, '0);
    check("R7 host clear", {31'd0, localRstOut}, 32'd0);

    // R6 reload trigger
    cur = hostRdData;
    busWrite(1'b1, cur | 32'h20000000, 1'b0, '0);
    check("R6 pulse", {30'd0, reloadPulse, hostRdData[29]}, 32'd3);
    @(negedge clk);
    check("R6 pulse one cycle", {31'd0, reloadPulse}, 32'd0);
    busWrite(1'b0, '0, 1'b1, cur | 32'h20000000);
    check("R6 no repulse", {30'd0, reloadPulse, hostRdData[29]}, 32'd1);
    @(negedge clk);
    reloadDone = 1'b1;
    @(negedge clk);
    reloadDone = 1'b0;
    check("R6 done clears", {31'd0, hostRdData[29]}, 32'd0);
    busWrite(1'b0, '0, 1'b1, cur | 32'h20000000);
    check("R6 rearm", {30'd0, reloadPulse, hostRdData[29]}, 32'd3);
    @(negedge clk);
    reloadDone = 1'b1;
    @(negedge clk);
    reloadDone = 1'b0;

    // R8 init flag, bypass and retry
    cur = hostRdData;
    check("R8 retry idle", {31'd0, hostRetry}, 32'd1);
    initBypassN = 1'b0;
    #1 check("R8 bypass", {30'd0, hostRdData[31], hostRetry}, 32'd2);
    @(negedge clk);
    initBypassN = 1'b1;
    #1 check("R8 bypass off", {31'd0, hostRetry}, 32'd1);
    busWrite(1'b1, cur | 32'h80000000, 1'b0, '0);
    check("R8 host set", {30'd0, hostRdData[31], hostRetry}, 32'd2);
    busWrite(1'b0, '0, 1'b1, cur);
    check("R8 local clear", {30'd0, hostRdData[31], hostRetry}, 32'd1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule